// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block joins two eight-input interrupt controllers, one master and one slave, into a single system of fifteen sources. It does not rank requests itself. Each controller reports its current winning line and whether it has one. The sequencer forwards a slave winner to the master's cascade input as a short pulse. It drives the processor interrupt line straight from the master's winner flag.

When the processor issues an acknowledge strobe, the sequencer picks the master winner and acknowledges it in the master. If that winner is the cascade line (2), it also acknowledges the slave winner. One cycle later it presents an 8-bit vector. The vector is formed from the upper five bits of the selected base and the three line bits. If a controller has no winner at acknowledge time, line 7 is used with that controller's base, and no acknowledge goes to that controller.

A poll read on the slave also produces a one-cycle strobe. This strobe tells the master to clear line 2 in both its request and in-service registers.

Top module: `casc_ack_seq`

## Requirements
- R1: `cpu_int_o` equals `mst_win_vld_i` in every cycle, combinationally.
- R2: A cascade pulse is armed out of reset. When it is armed and `slv_win_vld_i` is high at a clock edge, `cas_req_o` is high for exactly one cycle after that edge and the pulse is disarmed. A held slave winner produces no further pulse.
- R3: The cascade pulse is re-armed by any edge where `slv_win_vld_i` is low or `ack_i` is high, unless a pulse is launched at that same edge. A slave request still pending after an acknowledge therefore pulses line 2 again.
- R4: On `ack_i` with a master winner on a line other than 2, the next cycle shows `mst_ack_o`=1 with `mst_ack_line_o` equal to that line and `slv_ack_o`=0. The vector is `{mst_base_i[7:3], line}`; base bits [2:0] have no effect.
- R5: On `ack_i` with master winner line 2 and a slave winner, the next cycle shows a master acknowledge on line 2 and `slv_ack_o`=1 with the slave line. The vector is `{slv_base_i[7:3], slave line}`.
- R6: On `ack_i` with master winner line 2 and no slave winner, the next cycle shows a master acknowledge on line 2 and `slv_ack_o`=0. The vector is `{slv_base_i[7:3], 3'd7}`.
- R7: On `ack_i` with no master winner, the next cycle shows `mst_ack_o`=0 and `slv_ack_o`=0. The vector is `{mst_base_i[7:3], 3'd7}`.
- R8: `vec_vld_o` is high in exactly the cycles that follow an edge with `ack_i` high. While `vec_vld_o` is low, `vec_o`, `mst_ack_o`, `slv_ack_o` and both ack line outputs are zero.
- R9: `slv_poll_i` high at an edge gives `cas_clr_o` high for the following cycle only.
- R10: After a synchronous active-low reset, all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_win_vld_i | input | 1 | Master has a winning request |
| mst_win_line_i | input | 3 | Master winning line |
| slv_win_vld_i | input | 1 | Slave has a winning request |
| slv_win_line_i | input | 3 | Slave winning line |
| mst_base_i | input | 8 | Master vector base (bits [7:3] used) |
| slv_base_i | input | 8 | Slave vector base (bits [7:3] used) |
| ack_i | input | 1 | Processor acknowledge strobe |
| slv_poll_i | input | 1 | Poll read performed on the slave |
| cpu_int_o | output | 1 | Processor interrupt request |
| cas_req_o | output | 1 | Pulse into master input line 2 |
| mst_ack_o | output | 1 | Acknowledge to master |
| mst_ack_line_o | output | 3 | Line acknowledged in master |
| slv_ack_o | output | 1 | Acknowledge to slave |
| slv_ack_line_o | output | 3 | Line acknowledged in slave |
| vec_vld_o | output | 1 | Vector valid strobe |
| vec_o | output | 8 | Interrupt vector |
| cas_clr_o | output | 1 | Clear master line 2 request and in-service bits |

## Verification
A stuck arming flag shows up at `cas_req_o` in one of two ways. Either a held slave request keeps pulsing, or a request pending after an acknowledge never pulses again. Either symptom appears within two cycles of the stimulus. A wrong selection in the acknowledge path shows up one cycle after `ack_i`, as a wrong vector or a wrong set of acknowledge strobes. The bench steers the cascade, spurious-slave and spurious-master cases through the ports to expose it. Because the reference model is compared on every clock, any such error is reported in the cycle in which it first appears.

// File: rtl/casc_pkg.sv
// Shared widths and fixed line numbers for the cascade sequencer.
// Assumes both controllers have eight inputs and use 3-bit line numbers.
package casc_pkg;
    localparam int LINE_W    = 3;
    localparam int VEC_W     = 8;
    localparam int BASE_W    = VEC_W - LINE_W;
    localparam logic [LINE_W-1:0] CAS_LINE  = 3'd2;
    localparam logic [LINE_W-1:0] SPUR_LINE = 3'd7;

    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
    } win_t;
endpackage

// File: rtl/casc_req_pulser.sv
// Turns a slave winner into a one-cycle pulse on master cascade input.
// Assumes the slave winner flag is synchronous to clk. Re-arms when the
// slave has no winner or when an acknowledge is taken.
module casc_req_pulser (
    input  logic clk,
    input  logic rst_n,
    input  logic slv_vld_i,
    input  logic ack_i,
    output logic pulse_o
);
    logic armed_q;
    logic launch;

    assign launch = armed_q && slv_vld_i;

    // Arm flag and pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= launch;
            if (launch)
                armed_q <= 1'b0;
            else if (!slv_vld_i || ack_i)
                armed_q <= 1'b1;
        end
    end

    p_cas_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    p_cas_rearm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !slv_vld_i) |=> !pulse_o);
endmodule

// File: rtl/casc_ack_resolver.sv
// Resolves an acknowledge strobe into master/slave acks and a vector.
// Assumes winners are stable in the strobe cycle; outputs appear one
// cycle later for one cycle and are zero otherwise.
module casc_ack_resolver
    import casc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_i,
    input  win_t              mst_i,
    input  win_t              slv_i,
    input  logic [VEC_W-1:0]  mst_base_i,
    input  logic [VEC_W-1:0]  slv_base_i,
    output logic              mst_ack_o,
    output logic [LINE_W-1:0] mst_line_o,
    output logic              slv_ack_o,
    output logic [LINE_W-1:0] slv_line_o,
    output logic              vec_vld_o,
    output logic [VEC_W-1:0]  vec_o
);
    logic              cascade;
    logic [LINE_W-1:0] sel_line;
    logic [BASE_W-1:0] sel_base;

    // Choose base and line for the vector, with spurious fallback to line 7.
    always_comb begin
        cascade  = mst_i.vld && (mst_i.line == CAS_LINE);
        sel_base = cascade ? slv_base_i[VEC_W-1:LINE_W] : mst_base_i[VEC_W-1:LINE_W];
        if (cascade)
            sel_line = slv_i.vld ? slv_i.line : SPUR_LINE;
        else
            sel_line = mst_i.vld ? mst_i.line : SPUR_LINE;
    end

    // Register acknowledge outputs for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !ack_i) begin
            mst_ack_o  <= 1'b0;
            mst_line_o <= '0;
            slv_ack_o  <= 1'b0;
            slv_line_o <= '0;
            vec_vld_o  <= 1'b0;
            vec_o      <= '0;
        end else begin
            mst_ack_o  <= mst_i.vld;
            mst_line_o <= mst_i.vld ? mst_i.line : '0;
            slv_ack_o  <= cascade && slv_i.vld;
            slv_line_o <= (cascade && slv_i.vld) ? slv_i.line : '0;
            vec_vld_o  <= 1'b1;
            vec_o      <= {sel_base, sel_line};
        end
    end

    p_vec_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> vec_vld_o);
    p_vec_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> (!vec_vld_o && vec_o == '0));
    p_slv_needs_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slv_ack_o |-> (mst_ack_o && mst_line_o == CAS_LINE));
    p_spur_mst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !mst_i.vld) |=> (!mst_ack_o && !slv_ack_o));
endmodule

// File: rtl/casc_ack_seq.sv
// Top of the cascade sequencer: routes slave requests to master line 2,
// drives the processor interrupt, resolves acknowledges into a vector and
// forwards slave poll reads as a master line-2 clear.
// Assumes both controllers' winner outputs are synchronous to clk.
module casc_ack_seq
    import casc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mst_win_vld_i,
    input  logic [2:0]        mst_win_line_i,
    input  logic              slv_win_vld_i,
    input  logic [2:0]        slv_win_line_i,
    input  logic [7:0]        mst_base_i,
    input  logic [7:0]        slv_base_i,
    input  logic              ack_i,
    input  logic              slv_poll_i,
    output logic              cpu_int_o,
    output logic              cas_req_o,
    output logic              mst_ack_o,
    output logic [2:0]        mst_ack_line_o,
    output logic              slv_ack_o,
    output logic [2:0]        slv_ack_line_o,
    output logic              vec_vld_o,
    output logic [7:0]        vec_o,
    output logic              cas_clr_o
);
    win_t mst_w, slv_w;

    assign mst_w     = '{vld: mst_win_vld_i, line: mst_win_line_i};
    assign slv_w     = '{vld: slv_win_vld_i, line: slv_win_line_i};
    assign cpu_int_o = mst_win_vld_i;

    casc_req_pulser u_pulser (
        .clk       (clk),
        .rst_n     (rst_n),
        .slv_vld_i (slv_win_vld_i),
        .ack_i     (ack_i),
        .pulse_o   (cas_req_o)
    );

    casc_ack_resolver u_resolver (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_i      (ack_i),
        .mst_i      (mst_w),
        .slv_i      (slv_w),
        .mst_base_i (mst_base_i),
        .slv_base_i (slv_base_i),
        .mst_ack_o  (mst_ack_o),
        .mst_line_o (mst_ack_line_o),
        .slv_ack_o  (slv_ack_o),
        .slv_line_o (slv_ack_line_o),
        .vec_vld_o  (vec_vld_o),
        .vec_o      (vec_o)
    );

    // Forward a slave poll read as a one-cycle master line-2 clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cas_clr_o <= 1'b0;
        else
            cas_clr_o <= slv_poll_i;
    end

    p_poll_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        slv_poll_i |=> cas_clr_o);
    p_poll_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !slv_poll_i |=> !cas_clr_o);
endmodule

// File: tb/casc_ack_seq_tb.sv
module casc_ack_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mv = 0, sv = 0, ack = 0, poll = 0;
    logic [2:0] ml = 0, sl = 0;
    logic [7:0] mb = 0, sb = 0;
    logic cpu_int, cas, mack, sack, vv, clr;
    logic [2:0] mline, sline;
    logic [7:0] vec;

    int checks = 0, fails = 0;
    bit done = 0;
    // reference model state
    bit armed = 1;
    bit e_cas = 0, e_mack = 0, e_sack = 0, e_vv = 0, e_clr = 0;
    int e_mline = 0, e_sline = 0, e_vec = 0;

    always #4 clk = ~clk;

    casc_ack_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .mst_win_vld_i(mv), .mst_win_line_i(ml),
        .slv_win_vld_i(sv), .slv_win_line_i(sl),
        .mst_base_i(mb), .slv_base_i(sb),
        .ack_i(ack), .slv_poll_i(poll),
        .cpu_int_o(cpu_int), .cas_req_o(cas),
        .mst_ack_o(mack), .mst_ack_line_o(mline),
        .slv_ack_o(sack), .slv_ack_line_o(sline),
        .vec_vld_o(vv), .vec_o(vec), .cas_clr_o(clr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one cycle with the behavioural model, then compare all outputs.
    task automatic step();
        bit launch;
        int base, line;
        chk("R1", cpu_int, mv);
        if (!rst_n) begin
            armed = 1; e_cas = 0; e_mack = 0; e_sack = 0; e_vv = 0; e_clr = 0;
            e_mline = 0; e_sline = 0; e_vec = 0;
        end else begin
            launch = armed && sv;
            e_cas = launch;
            if (launch) armed = 0;
            else if (!sv || ack) armed = 1;
            e_clr = poll;
            e_mack = 0; e_sack = 0; e_vv = 0; e_mline = 0; e_sline = 0; e_vec = 0;
            if (ack) begin
                e_vv = 1;
                if (mv && ml == 3'd2) begin
                    e_mack = 1; e_mline = 2;
                    base = sb / 8 * 8;
                    line = sv ? int'(sl) : 7;
                    e_sack = sv; e_sline = sv ? int'(sl) : 0;
                end else if (mv) begin
                    e_mack = 1; e_mline = ml;
                    base = mb / 8 * 8; line = ml;
                end else begin
                    base = mb / 8 * 8; line = 7;
                end
                e_vec = base + line;
            end
        end
        @(posedge clk); #1;
        chk("R2/R3 cas", cas, e_cas);
        chk("R4-R7 mack", mack, e_mack);
        chk("R4-R7 mline", mline, e_mline);
        chk("R5 R6 sack", sack, e_sack);
        chk("R5 sline", sline, e_sline);
        chk("R8 vv", vv, e_vv);
        chk("R4-R7 vec", vec, e_vec);
        chk("R9 clr", clr, e_clr);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        step(); step();
        rst_n = 1;
        step();
        // R2: slave winner held -> single pulse
        sv = 1; sl = 3'd5;
        step(); step(); step();
        // R3: drop slave, re-raise -> pulse again
        sv = 0; step();
        sv = 1; step(); step();
        // R5: cascade acknowledge with slave winner; R3 re-arm via ack
        mv = 1; ml = 3'd2; sb = 8'h77; mb = 8'h08; ack = 1;
        step(); ack = 0;
        step(); step(); step();
        // R6: cascade with no slave winner (spurious slave)
        sv = 0; ack = 1; step(); ack = 0; step();
        // R4: plain master winner, base low bits ignored
        ml = 3'd6; mb = 8'h27; ack = 1; step(); ack = 0; step();
        ml = 3'd0; mb = 8'hF8; ack = 1; step(); step(); ack = 0; step();
        // R7: no master winner (spurious master)
        mv = 0; mb = 8'h41; ack = 1; step(); ack = 0; step();
        // R9: poll strobe
        poll = 1; step(); poll = 0; step(); step();
        // R1 + R2: pulse launch coinciding with acknowledge
        sv = 1; sl = 3'd1; mv = 1; ml = 3'd2; sb = 8'hA0; ack = 1;
        step(); ack = 0; step(); step();
        // R10: reset mid-activity
        ack = 1; poll = 1; rst_n = 0; step(); ack = 0; poll = 0; step();
        rst_n = 1; sv = 0; mv = 0; step(); step();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule